// File: doc/BRIEF.md
# Converter Code Register and Update Controller

This block sits between a serial command receiver and a single-channel converter core. It keeps a staging register, the live converter code register and a power-down flag. When the receiver has captured a full word and the chip-select/load line has risen, it pulses a strobe along with a 4-bit opcode and a 16-bit data field. The block decodes that opcode. It can stage the data, commit it to the live code, do both, or put the converter to sleep.

An active-low load-request input (`ldac_n`) gives a second way to commit the staged code. Its effect depends on the chip-select/load level:

- With select high, a falling edge commits at once.
- A pulse that ends while select is low only wakes the converter.
- A request still held low when the strobe arrives forces a commit after the command has run. It also cancels a sleep command in that word.

An active-low clear input resets all state asynchronously. A ready flag follows the end of sleep by a fixed number of cycles, which models the time the analog path needs to settle.

Top module: `dac_update_ctrl`

## Requirements
- R1: On a strobe with opcode 4'b0000, the staging register takes the data field and the live code `dac_code` does not change.
- R2: A strobe with opcode 4'b1111, or with any code other than 0000, 0001, 0011 and 0100, changes neither register nor `pwr_dn` when `ldac_n` is high.
- R3: On a strobe with opcode 4'b0001, `dac_code` takes the staging register value on the next cycle and `pwr_dn` goes low.
- R4: On a strobe with opcode 4'b0011, the data field is staged and committed to `dac_code` in the same cycle, and `pwr_dn` goes low.
- R5: On a strobe with opcode 4'b0100, `pwr_dn` goes high. The data field is ignored and both registers keep their contents.
- R6: While `cs_ld` is high, a high-to-low change on `ldac_n` copies the staging register into `dac_code` on that clock edge.
- R7: A low `ldac_n` clears `pwr_dn` whatever the level of `cs_ld`. A low pulse that ends while `cs_ld` is low does not change `dac_code`.
- R8: If `ldac_n` is low during a strobe, the command executes and `dac_code` is then loaded from the resulting staging value.
- R9: If `ldac_n` is low during a strobe with opcode 4'b0100, `pwr_dn` does not go high.
- R10: `ready` is low while `pwr_dn` is high. After `pwr_dn` falls, `ready` stays low for exactly `PU_DLY` cycles and then rises.
- R11: A low on `clr_n` at once sets `dac_code` and the staging register to zero, `pwr_dn` low and `ready` high. After clear, the code stays zero until a write is followed by a commit.
- R12: `dac_code` holds the upper `DW` bits of the 16-bit data field (bits 15 down to 16-DW); the lower bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| cs_ld | input | 1 | Chip-select/load level from the serial side |
| ldac_n | input | 1 | Load request, active low, synchronous to clk |
| cmd_stb | input | 1 | One-cycle pulse: a complete command word is present |
| cmd | input | 4 | Opcode |
| data | input | 16 | Data field, code left-justified |
| dac_code | output | DW | Live code driven to the converter |
| pwr_dn | output | 1 | Converter is in sleep |
| ready | output | 1 | Converter awake and settled |

## Verification
The staging register has no port of its own, so a wrong value there is invisible until a later commit. Each opcode case therefore ends with a plain 0001 commit that exposes the staged value on `dac_code` one cycle later. A wrong commit decision or a wrong sleep decision shows up on `dac_code` or `pwr_dn` on the cycle after the strobe or the `ldac_n` edge. A wrong settling counter shows as `ready` rising one or more cycles away from `PU_DLY`. The bench sweeps every opcode against both `ldac_n` levels and both starting sleep states.

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl #(
  parameter int DW     = 16,
  parameter int PU_DLY = 8
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          cs_ld,
  input  logic          ldac_n,
  input  logic          cmd_stb,
  input  logic [3:0]    cmd,
  input  logic [15:0]   data,
  output logic [DW-1:0] dac_code,
  output logic          pwr_dn,
  output logic          ready
);

  localparam int             CW      = $clog2(PU_DLY + 1);
  localparam logic [CW-1:0]  CNT_MAX = CW'(PU_DLY);
  localparam logic [3:0]     OP_WR    = 4'b0000;
  localparam logic [3:0]     OP_UPD   = 4'b0001;
  localparam logic [3:0]     OP_WRUPD = 4'b0011;
  localparam logic [3:0]     OP_SLEEP = 4'b0100;

  logic [DW-1:0] stage_q;
  logic [DW-1:0] stage_d;
  logic          ldac_q;
  logic [CW-1:0] settle_q;

  logic is_wr, is_upd, is_sleep, held_req, req_fall, commit;

  assign is_wr    = cmd_stb & ((cmd == OP_WR) | (cmd == OP_WRUPD));
  assign is_upd   = cmd_stb & ((cmd == OP_UPD) | (cmd == OP_WRUPD));
  assign is_sleep = cmd_stb & (cmd == OP_SLEEP);
  assign held_req = cmd_stb & ~ldac_n;
  assign req_fall = ldac_q & ~ldac_n & cs_ld;
  assign commit   = is_upd | held_req | req_fall;
  assign stage_d  = is_wr ? data[15 -: DW] : stage_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      stage_q  <= '0;
      dac_code <= '0;
      pwr_dn   <= 1'b0;
      ldac_q   <= 1'b1;
      settle_q <= CNT_MAX;
    end else begin
      ldac_q  <= ldac_n;
      stage_q <= stage_d;
      if (commit) dac_code <= stage_d;
      if (!ldac_n || commit) pwr_dn <= 1'b0;
      else if (is_sleep)     pwr_dn <= 1'b1;
      if (pwr_dn)                   settle_q <= '0;
      else if (settle_q != CNT_MAX) settle_q <= settle_q + 1'b1;
    end
  end

  assign ready = ~pwr_dn & (settle_q == CNT_MAX);

  AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!clr_n)
    (cmd_stb && cmd == 4'hF && ldac_n) |=> ($stable(dac_code) && $stable(pwr_dn))); // R2
  AST_UPD_WAKES: assert property (@(posedge clk) disable iff (!clr_n)
    (cmd_stb && cmd == 4'h1) |=> !pwr_dn); // R3
  AST_SLEEP_KEEPS_CODE: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(pwr_dn) |-> $stable(dac_code)); // R5
  AST_REQ_WAKES: assert property (@(posedge clk) disable iff (!clr_n)
    !ldac_n |=> !pwr_dn); // R7
  AST_SETTLE_WAIT: assert property (@(posedge clk) disable iff (!clr_n)
    $fell(pwr_dn) |-> !ready); // R10

endmodule

// File: tb/dac_update_ctrl_bench.sv
module dac_update_ctrl_bench;
  localparam int DW = 12;
  localparam int PU = 4;

  logic clk = 1'b0;
  logic clr_n = 1'b0, cs_ld = 1'b1, ldac_n = 1'b1, cmd_stb = 1'b0;
  logic [3:0]  cmd = '0;
  logic [15:0] data = '0;
  logic [DW-1:0] dac_code;
  logic pwr_dn, ready;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dac_update_ctrl #(.DW(DW), .PU_DLY(PU)) u_dac_update_ctrl (
    .clk(clk), .clr_n(clr_n), .cs_ld(cs_ld), .ldac_n(ldac_n), .cmd_stb(cmd_stb),
    .cmd(cmd), .data(data), .dac_code(dac_code), .pwr_dn(pwr_dn), .ready(ready));

  function automatic logic [DW-1:0] top(input logic [15:0] d);
    return d[15 -: DW];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [15:0] d, input logic ld);
    cmd_stb = 1'b1; cmd = c; data = d; ldac_n = ld;
    @(negedge clk);
    cmd_stb = 1'b0; ldac_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 reset code", dac_code, 0);
    chk("R11 reset pwr_dn", pwr_dn, 0);
    chk("R11 reset ready", ready, 1);
    clr_n = 1'b1;
    @(negedge clk);

    for (int pd0 = 0; pd0 < 2; pd0++) begin
      for (int c = 0; c < 16; c++) begin
        for (int lv = 0; lv < 2; lv++) begin
          logic [15:0] a, b, d;
          logic [DW-1:0] e_in, e_dac;
          logic e_pd, upd;
          a = 16'h0F0F ^ 16'((pd0 * 32 + c * 2 + lv) * 16'h0731);
          b = a ^ 16'h5A5A;
          d = ~a ^ 16'h0003;
          issue(4'h0, a, 1'b1);
          issue(4'h1, 16'h0, 1'b1);
          issue(4'h0, b, 1'b1);
          if (pd0 == 1) issue(4'h4, 16'hFFFF, 1'b1);
          e_in  = (c == 0 || c == 3) ? top(d) : top(b);
          upd   = (c == 1 || c == 3 || lv == 0);
          e_dac = upd ? e_in : top(a);
          e_pd  = (lv == 0 || upd) ? 1'b0 : (c == 4) ? 1'b1 : 1'(pd0);
          issue(4'(c), d, 1'(lv));
          if (c == 0 && lv == 1)       chk("R1 code held", dac_code, e_dac);
          else if (c == 1 && lv == 1)  chk("R3 commit", dac_code, e_dac);
          else if (c == 3 && lv == 1)  chk("R4 write+commit", dac_code, e_dac);
          else if (c == 4 && lv == 1)  chk("R5 sleep code", dac_code, e_dac);
          else if (lv == 0)            chk("R8 held request commit", dac_code, e_dac);
          else                         chk("R2 no-op code", dac_code, e_dac);
          if (c == 4 && lv == 0)       chk("R9 sleep vetoed", pwr_dn, e_pd);
          else if (c == 4)             chk("R5 sleep flag", pwr_dn, e_pd);
          else                         chk("R2 R3 R4 R8 pwr_dn", pwr_dn, e_pd);
          issue(4'h1, 16'h0, 1'b1);
          chk("R1 R5 R12 staged value", dac_code, e_in);
        end
      end
    end

    issue(4'h0, 16'hABCD, 1'b1);
    issue(4'h1, 16'h0, 1'b1);
    chk("R12 upper bits", dac_code, 12'hABC);

    issue(4'h0, 16'h1357, 1'b1);
    issue(4'h4, 16'h0, 1'b1);
    chk("R10 ready low in sleep", ready, 0);
    cs_ld = 1'b0;
    ldac_n = 1'b0;
    @(negedge clk);
    ldac_n = 1'b1;
    chk("R7 wake during select low", pwr_dn, 0);
    chk("R7 no commit on pulse", dac_code, 12'hABC);
    @(negedge clk);
    cs_ld = 1'b1;
    @(negedge clk);
    chk("R7 no commit after select", dac_code, 12'hABC);
    ldac_n = 1'b0;
    @(negedge clk);
    ldac_n = 1'b1;
    chk("R6 immediate commit", dac_code, 12'h135);

    issue(4'h4, 16'h0, 1'b1);
    issue(4'h1, 16'h0, 1'b1);
    for (int k = 0; k < PU; k++) begin
      chk("R10 settle low", ready, 0);
      @(negedge clk);
    end
    chk("R10 ready rises", ready, 1);

    issue(4'h4, 16'h0, 1'b1);
    #2 clr_n = 1'b0;
    #1;
    chk("R11 async code", dac_code, 0);
    chk("R11 async pwr_dn", pwr_dn, 0);
    chk("R11 async ready", ready, 1);
    @(negedge clk);
    clr_n = 1'b1;
    @(negedge clk);
    issue(4'h0, 16'h7770, 1'b1);
    chk("R11 zero until commit", dac_code, 0);
    issue(4'h1, 16'h0, 1'b1);
    chk("R11 commit after clear", dac_code, 12'h777);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule